// File: doc/BRIEF.md
# Maskable Interrupt Request Collector

This block gathers event requests from two kinds of sources into sticky flags. The first kind is a set of already synchronized external pin levels, each turned into an event on the edge direction chosen for that pin. The second is a set of single-cycle pulses from on-chip peripherals. Each flag has a mask bit beside it. The block drives one general interrupt request line to the processor. That line is the OR of every flag that is set and also unmasked, gated by a global enable.

Software sees the flags as groups of `BUS_W` bits, chosen by a group select. Reading a group returns its flags on the next cycle and clears them at the same time. An event that arrives in the very cycle of the clear is not lost. Single flags can also be cleared by a bit pattern. Software can write the global enable. When the processor signals that it is entering halt, the block sets the global enable again on its own, so a pending request can wake the processor.

Top module: `irq_gather`

## Requirements
- R1: During and right after a synchronous reset, all flags, all mask bits and the global enable are 0, `irq_req` is 0 and `rd_data` is 0.
- R2: Flag bit positions form one vector: external pin events in bits 0 up to NUM_EXT-1, then internal pulses above them. Group `g` holds vector bits `g*BUS_W` up to `g*BUS_W+BUS_W-1`. With the default sizes, group 0 holds pin 0, pin 1, internal 0 and internal 1 in bits 0 to 3, and group 1 holds internals 2 to 5 in bits 0 to 3. A high `int_pulse` bit during a clock edge sets its flag at that edge.
- R3: When `ext_rise[i]` is 1, a 0-to-1 change of `ext_lvl[i]` between two edges sets the pin's flag. When it is 0, a 1-to-0 change sets the flag. A change in the other direction sets nothing.
- R4: A flag latches even while its mask bit is 0. A masked flag never raises `irq_req`.
- R5: With `rd_en` high at an edge, `rd_data` holds the selected group's flags as they stood before that edge, from the cycle after it onward. The flags of that group are cleared at that edge. Otherwise `rd_data` holds its value.
- R6: An event arriving at the same edge as a read or a software clear of its flag leaves the flag set.
- R7: With `clr_en` high, each 1 in `clr_bits` clears the matching flag of the selected group. Flags under 0 bits and flags of other groups stay as they were.
- R8: `irq_req` is registered. After each edge it equals the global enable ANDed with the OR of all flag-and-mask pairs, taken as they stood before that edge.
- R9: `gen_we` loads the global enable from `gen_val`. `halt_enter` sets it to 1 and wins over a write in the same cycle.
- R10: `msk_we` loads `msk_data` into the mask bits of the selected group only. Mask bit k masks flag bit k of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_lvl | input | NUM_EXT | Synchronized external pin levels |
| ext_rise | input | NUM_EXT | Per-pin edge choice: 1 rising, 0 falling |
| int_pulse | input | NUM_INT | Single-cycle internal event pulses |
| reg_sel | input | SEL_W | Flag/mask group select |
| rd_en | input | 1 | Read the selected flag group and clear it |
| rd_data | output | BUS_W | Registered read data |
| clr_en | input | 1 | Clear flags of the selected group by pattern |
| clr_bits | input | BUS_W | Flags to clear, one bit each |
| msk_we | input | 1 | Write mask bits of the selected group |
| msk_data | input | BUS_W | Mask value, 1 lets the flag through |
| gen_we | input | 1 | Write the global enable |
| gen_val | input | 1 | Global enable value |
| halt_enter | input | 1 | Processor entering halt; sets the global enable |
| irq_req | output | 1 | General interrupt request |

## Verification
The bench builds the block with its default sizes: two pins, six internal sources and a 4-bit bus. That makes exactly two full groups, so every flag, both group selects and the split of group 0 between pin and internal sources can be reached. A bench model follows the flags, masks, enable and previous pin levels. Random traffic then lets reads, pattern clears, mask writes and halts collide with events in the same cycle. Directed steps pin down bit positions, edge polarity and the win of halt over an enable write.

// File: rtl/irq_pkg.sv
package irq_pkg;
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] rise_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    prev_q <= lvl_i;
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      evt_o[i] = rise_i[i] ? (lvl_i[i] & ~prev_q[i]) : (~lvl_i[i] & prev_q[i]);
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_rise_evt_R3: assert property (@(posedge clk) disable iff (rst)
      (rise_i[i] && $rose(lvl_i[i])) |-> evt_o[i]);
    assert_wrong_dir_R3: assert property (@(posedge clk) disable iff (rst)
      (rise_i[i] && $fell(lvl_i[i])) |-> !evt_o[i]);
    assert_fall_evt_R3: assert property (@(posedge clk) disable iff (rst)
      (!rise_i[i] && $fell(lvl_i[i])) |-> evt_o[i]);
  end
endmodule

// File: rtl/irq_flag_grp.sv
module irq_flag_grp #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         msk_we,
  input  logic [W-1:0] msk_d,
  output logic [W-1:0] flag_o,
  output logic         pend_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= '0;
      mask_q <= '0;
    end else begin
      flag_o <= (flag_o & ~clr_i) | set_i;
      if (msk_we) mask_q <= msk_d;
    end
  end

  assign pend_o = |(flag_o & mask_q);

  for (genvar b = 0; b < W; b++) begin : g_chk
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
      set_i[b] |=> flag_o[b]);
    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      (flag_o[b] && !clr_i[b]) |=> flag_o[b]);
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (clr_i[b] && !set_i[b]) |=> !flag_o[b]);
  end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_pkg::*;
#(
  parameter int NUM_EXT = 2,
  parameter int NUM_INT = 6,
  parameter int BUS_W   = 4,
  localparam int TOTAL   = NUM_EXT + NUM_INT,
  localparam int NUM_GRP = ceil_div(TOTAL, BUS_W),
  localparam int PAD     = NUM_GRP * BUS_W,
  localparam int SEL_W   = sel_width(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] ext_lvl,
  input  logic [NUM_EXT-1:0] ext_rise,
  input  logic [NUM_INT-1:0] int_pulse,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic               rd_en,
  output logic [BUS_W-1:0]   rd_data,
  input  logic               clr_en,
  input  logic [BUS_W-1:0]   clr_bits,
  input  logic               msk_we,
  input  logic [BUS_W-1:0]   msk_data,
  input  logic               gen_we,
  input  logic               gen_val,
  input  logic               halt_enter,
  output logic               irq_req
);
  logic [NUM_EXT-1:0] ext_evt;
  logic [PAD-1:0]     src_vec;
  logic [BUS_W-1:0]   grp_flag [NUM_GRP];
  logic [NUM_GRP-1:0] grp_pend;
  logic [BUS_W-1:0]   rd_mux;
  logic               gen_en;

  irq_edge_det #(.N(NUM_EXT)) i_edge (
    .clk(clk), .rst(rst), .lvl_i(ext_lvl), .rise_i(ext_rise), .evt_o(ext_evt)
  );

  always_comb begin
    src_vec = '0;
    src_vec[TOTAL-1:0] = {int_pulse, ext_evt};
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic             hit;
    logic [BUS_W-1:0] clr_vec;
    assign hit     = (reg_sel == SEL_W'(g));
    assign clr_vec = hit ? ({BUS_W{rd_en}} | (clr_en ? clr_bits : '0)) : '0;
    irq_flag_grp #(.W(BUS_W)) i_grp (
      .clk(clk), .rst(rst),
      .set_i(src_vec[g*BUS_W +: BUS_W]),
      .clr_i(clr_vec),
      .msk_we(msk_we && hit),
      .msk_d(msk_data),
      .flag_o(grp_flag[g]),
      .pend_o(grp_pend[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (reg_sel == SEL_W'(g)) rd_mux = grp_flag[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en  <= 1'b0;
      irq_req <= 1'b0;
      rd_data <= '0;
    end else begin
      if (halt_enter)  gen_en <= 1'b1;
      else if (gen_we) gen_en <= gen_val;
      irq_req <= gen_en & (|grp_pend);
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assert_halt_arms_R9: assert property (@(posedge clk) disable iff (rst)
    halt_enter |=> gen_en);
  assert_gate_off_R8: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> !irq_req);
  assert_no_pend_R4: assert property (@(posedge clk) disable iff (rst)
    (grp_pend == '0) |=> !irq_req);
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/test_irq_gather.sv
module test_irq_gather;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_lvl = '0, ext_rise = '0;
  logic [5:0] int_pulse = '0;
  logic       reg_sel = 1'b0, rd_en = 1'b0, clr_en = 1'b0, msk_we = 1'b0;
  logic [3:0] clr_bits = '0, msk_data = '0, rd_data;
  logic       gen_we = 1'b0, gen_val = 1'b0, halt_enter = 1'b0, irq_req;

  int total = 0, bad = 0;
  logic [7:0] flags_m = '0, masks_m = '0;
  logic       gen_m = 1'b0;
  logic [1:0] prv_m = '0;
  logic [3:0] rd_last = '0;

  always #10 clk = ~clk;

  irq_gather i_irq_gather (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .ext_rise(ext_rise),
    .int_pulse(int_pulse), .reg_sel(reg_sel), .rd_en(rd_en), .rd_data(rd_data),
    .clr_en(clr_en), .clr_bits(clr_bits), .msk_we(msk_we), .msk_data(msk_data),
    .gen_we(gen_we), .gen_val(gen_val), .halt_enter(halt_enter), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] edges(input logic [1:0] prv, input logic [1:0] cur,
                                       input logic [1:0] rise);
    logic [1:0] e;
    for (int i = 0; i < 2; i++)
      e[i] = rise[i] ? (cur[i] & ~prv[i]) : (prv[i] & ~cur[i]);
    return e;
  endfunction

  task automatic step(input logic [1:0] e, input logic [5:0] ip, input logic sel,
                      input logic rd, input logic clr, input logic [3:0] cb,
                      input logic mw, input logic [3:0] md, input logic gw,
                      input logic gv, input logic hl, input string tag);
    logic [7:0] src, clrv;
    logic irq_exp;
    ext_lvl = e; int_pulse = ip; reg_sel = sel; rd_en = rd; clr_en = clr;
    clr_bits = cb; msk_we = mw; msk_data = md; gen_we = gw; gen_val = gv; halt_enter = hl;
    src = {ip, edges(prv_m, e, ext_rise)};
    prv_m = e;
    irq_exp = gen_m & (|(flags_m & masks_m));
    clrv = '0;
    clrv[sel*4 +: 4] = {4{rd}} | (clr ? cb : 4'b0);
    if (rd) rd_last = flags_m[sel*4 +: 4];
    flags_m = (flags_m & ~clrv) | src;
    if (mw) masks_m[sel*4 +: 4] = md;
    if (hl) gen_m = 1'b1; else if (gw) gen_m = gv;
    @(posedge clk);
    @(negedge clk);
    int_pulse = '0; rd_en = 0; clr_en = 0; msk_we = 0; gen_we = 0; halt_enter = 0;
    chk({tag, " irq R8"}, {3'b0, irq_req}, {3'b0, irq_exp});
    chk({tag, " rd_data R5"}, rd_data, rd_last);
  endtask

  task automatic idle(input string tag);
    step(ext_lvl, 6'b0, 1'b0, 0, 0, 4'b0, 0, 4'b0, 0, 0, 0, tag);
  endtask

  task automatic rd(input logic sel, input string tag);
    step(ext_lvl, 6'b0, sel, 1, 0, 4'b0, 0, 4'b0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    chk("R1 irq in reset", {3'b0, irq_req}, 4'b0);
    @(negedge clk);
    rst = 0;
    chk("R1 rd_data after reset", rd_data, 4'b0);
    rd(0, "R1 group0");
    chk("R1 group0 empty", rd_data, 4'b0);
    rd(1, "R1 group1");
    chk("R1 group1 empty", rd_data, 4'b0);

    // R2: bit positions
    step(2'b00, 6'b000001, 0, 0, 0, 4'b0, 0, 4'b0, 0, 0, 0, "R2 int0");
    rd(0, "R2");
    chk("R2 int0 in g0 bit2", rd_data, 4'b0100);
    step(2'b00, 6'b100000, 0, 0, 0, 4'b0, 0, 4'b0, 0, 0, 0, "R2 int5");
    rd(1, "R2");
    chk("R2 int5 in g1 bit3", rd_data, 4'b1000);

    // R3: pin0 rising, pin1 falling
    ext_rise = 2'b01;
    step(2'b01, 6'b0, 0, 0, 0, 4'b0, 0, 4'b0, 0, 0, 0, "R3 rise pin0");
    step(2'b11, 6'b0, 0, 0, 0, 4'b0, 0, 4'b0, 0, 0, 0, "R3 rise pin1");
    rd(0, "R3");
    chk("R3 only pin0 rise", rd_data, 4'b0001);
    step(2'b00, 6'b0, 0, 0, 0, 4'b0, 0, 4'b0, 0, 0, 0, "R3 fall both");
    rd(0, "R3");
    chk("R3 only pin1 fall", rd_data, 4'b0010);

    // R4 / R8: masked flag latches, no irq
    step(2'b00, 6'b001000, 0, 0, 0, 4'b0, 0, 4'b0, 1, 1, 0, "R4 masked");
    idle("R4");
    chk("R4 masked no irq", {3'b0, irq_req}, 4'b0);
    step(2'b00, 6'b0, 1, 0, 0, 4'b0, 1, 4'b0010, 0, 0, 0, "R4 unmask");
    idle("R8");
    chk("R8 irq raised", {3'b0, irq_req}, 4'b0001);
    step(2'b00, 6'b0, 0, 0, 0, 4'b0, 0, 4'b0, 1, 0, 0, "R8 disable");
    idle("R8");
    chk("R8 irq gated", {3'b0, irq_req}, 4'b0);

    // R9: halt wins over enable write of 0
    step(2'b00, 6'b0, 0, 0, 0, 4'b0, 0, 4'b0, 1, 0, 1, "R9 halt");
    idle("R9");
    chk("R9 halt rearms", {3'b0, irq_req}, 4'b0001);

    // R6: event during read of the same group
    step(2'b00, 6'b001000, 1, 1, 0, 4'b0, 0, 4'b0, 0, 0, 0, "R6 read+event");
    chk("R6 old value read", rd_data, 4'b0010);
    rd(1, "R6");
    chk("R6 event kept", rd_data, 4'b0010);

    // R7: pattern clear
    step(2'b00, 6'b001100, 0, 0, 0, 4'b0, 0, 4'b0, 0, 0, 0, "R7 set");
    step(2'b00, 6'b000001, 1, 0, 1, 4'b0001, 0, 4'b0, 0, 0, 0, "R7 clr");
    rd(1, "R7");
    chk("R7 bit1 left", rd_data, 4'b0010);
    rd(0, "R7");
    chk("R7 other group kept", rd_data, 4'b0100);

    // R10: mask write reaches selected group only
    step(2'b00, 6'b000100, 1, 0, 0, 4'b0, 1, 4'b0000, 0, 0, 0, "R10 g1 mask off");
    step(2'b00, 6'b0, 0, 0, 0, 4'b0, 1, 4'b1111, 0, 0, 0, "R10 g0 mask on");
    idle("R10");
    chk("R10 g1 still masked", {3'b0, irq_req}, 4'b0);

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:29] == 3'b0) ext_rise = r[28:27];
      step(r[1:0], (r[4:2] == 3'b0) ? r[10:5] : 6'b0, r[11], r[14:12] == 3'b0,
           r[17:15] == 3'b0, r[21:18], r[24:22] == 3'b0, r[21:18],
           r[26:25] == 2'b0, r[5], r[30:26] == 5'b0, "rnd R2 R3 R5 R6 R7 R9 R10");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule